// File: doc/BRIEF.md
# Sleep Wake-Up Source Controller

This block decides when a device sleeping in low-power mode must be woken. It watches a set of general-purpose input lines and a real-time-clock alarm. Each input line passes through a synchronizer and an edge detector. Per-line rising and falling enables choose which transitions count as events. A wake-enable register selects which lines, and whether the alarm, may actually wake the device. Any qualifying event raises a one-cycle wake request.

Software programs the block through a simple word-addressed register port. Two active-low power-fault pins act as a safety override. While either pin is low, the wake enables are forced back to a safe set in which only the two lowest lines are enabled. An ignore-fault control bit turns this override off. Lines that are configured as outputs never produce a wake, whatever their enables say.

Top module: `wake_src_ctrl`

## Requirements
- R1: The register map uses byte offsets on `reg_addr`. Offset 0x0 is the wake-enable register: bits 15:0 enable the GPIO lines and bit 31 enables the alarm. Offset 0x4 holds the rising-edge enables and offset 0x8 the falling-edge enables, both in bits 15:0. Offset 0xC is the control register, with bit 0 as ignore-fault. `reg_rdata` shows the addressed register in the same cycle, and every other offset reads as zero.
- R2: After reset, the wake-enable register reads 0x0000_0003. The rising, falling and control registers read zero.
- R3: Both fault pins pass through a two-flop synchronizer. While ignore-fault is 0 and either synchronized pin is low, the wake-enable register is loaded with 0x0000_0003 on every clock edge.
- R4: While ignore-fault is 1, the fault pins leave the wake-enable register unchanged.
- R5: Reserved bits always read as zero, and writes to them are dropped. These are wake-enable bits 30:16, edge-enable bits 31:16 and control bits 31:1.
- R6: A 0-to-1 change on a line whose rising and wake enables are set produces a one-cycle `wake_req` pulse. The pulse is visible after the third rising clock edge following the change.
- R7: A 1-to-0 change on a line wakes only when that line's falling enable is set. A line with both edge enables set wakes on both transitions. A line with neither edge enable set never wakes.
- R8: An edge on a line whose wake-enable bit is clear produces no wake.
- R9: A line marked as an output in `gpio_is_out` produces no wake, even with all of its enables set.
- R10: An `rtc_alarm` pulse with wake-enable bit 31 set produces `wake_req` on the next clock edge. With bit 31 clear, the pulse has no effect.
- R11: When an active fault override and a software write to the wake-enable register fall in the same cycle, the override wins and the register holds 0x0000_0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, shared by all reset causes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| gpio_in | input | NUM_GPIO | Asynchronous GPIO input levels |
| gpio_is_out | input | NUM_GPIO | Per-line flag, 1 when the line is driven as an output |
| rtc_alarm | input | 1 | Synchronous one-cycle alarm pulse |
| vdd_fault_n | input | 1 | Active-low supply fault pin |
| batt_fault_n | input | 1 | Active-low battery fault pin |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench builds the block with 16 lines, a two-stage synchronizer and a 4-bit offset. With these values, the full register map and the odd unmapped offsets fall inside the address range. With the two-stage synchronizer, the edge-to-wake latency is a fixed three clock edges, so every wake pulse can be sampled in a known cycle. With 16 lines, the wide writes reach the reserved bits 30:16, so the bench can show that they are dropped. Both fault pins, the ignore-fault bit and the collision between the fault override and a software write are each driven in directed scenarios.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int REG_W = 32;

  // Byte offsets of the registers
  localparam int OFS_WEN  = 'h0;
  localparam int OFS_RISE = 'h4;
  localparam int OFS_FALL = 'h8;
  localparam int OFS_CTRL = 'hC;

  localparam logic [REG_W-1:0] WEN_SAFE = 32'h0000_0003;
  localparam int RTC_BIT = 31;

  // Mask of the implemented GPIO bits
  function automatic logic [REG_W-1:0] line_mask(input int n);
    return (32'h1 << n) - 32'h1;
  endfunction

  // Writable bits of the wake-enable register
  function automatic logic [REG_W-1:0] wen_wmask(input int n);
    return line_mask(n) | (32'h1 << RTC_BIT);
  endfunction

  // Per-line qualified event: the edge is selected and the line is an input
  function automatic logic [REG_W-1:0] qual_events(
    input logic [REG_W-1:0] rise_evt,
    input logic [REG_W-1:0] fall_evt,
    input logic [REG_W-1:0] rise_en,
    input logic [REG_W-1:0] fall_en,
    input logic [REG_W-1:0] is_out
  );
    return ((rise_evt & rise_en) | (fall_evt & fall_en)) & ~is_out;
  endfunction

  // Final wake decision
  function automatic logic wake_hit(
    input logic [REG_W-1:0] evt,
    input logic [REG_W-1:0] en,
    input logic             rtc,
    input logic             rtc_en
  );
    return (|(evt & en)) | (rtc & rtc_en);
  endfunction

endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int NUM_GPIO    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GPIO-1:0] pin_in,
  output logic [NUM_GPIO-1:0] rise_evt,
  output logic [NUM_GPIO-1:0] fall_evt
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], pin_in[g]};
        prev  <= chain[LAST];
      end
    end

    assign rise_evt[g] =  chain[LAST] & ~prev;
    assign fall_evt[g] = ~chain[LAST] &  prev;
  end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int NUM_GPIO = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic                vdd_fault_n,
  input  logic                batt_fault_n,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_GPIO-1:0] wen_gpio,
  output logic                wen_rtc,
  output logic [NUM_GPIO-1:0] rise_en,
  output logic [NUM_GPIO-1:0] fall_en,
  output logic                ign_fault,
  output logic                fault_force
);

  localparam logic [ADDR_W-1:0] A_WEN  = ADDR_W'(OFS_WEN);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [REG_W-1:0]  M_WEN  = wen_wmask(NUM_GPIO);
  localparam logic [REG_W-1:0]  M_EDGE = line_mask(NUM_GPIO);

  logic [REG_W-1:0] wen_q, rise_q, fall_q, ctrl_q;
  logic [1:0]       vdd_s, batt_s;
  logic             fault_seen;

  // Fault pin synchronizers, idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vdd_s  <= 2'b11;
      batt_s <= 2'b11;
    end else begin
      vdd_s  <= {vdd_s[0], vdd_fault_n};
      batt_s <= {batt_s[0], batt_fault_n};
    end
  end

  assign fault_seen  = ~vdd_s[1] | ~batt_s[1];
  assign fault_force = fault_seen & ~ctrl_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= WEN_SAFE;
      rise_q <= '0;
      fall_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (fault_force)
        wen_q <= WEN_SAFE;
      else if (reg_wr && reg_addr == A_WEN)
        wen_q <= reg_wdata & M_WEN;
      if (reg_wr && reg_addr == A_RISE) rise_q <= reg_wdata & M_EDGE;
      if (reg_wr && reg_addr == A_FALL) fall_q <= reg_wdata & M_EDGE;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & 32'h1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_WEN:   reg_rdata = wen_q;
      A_RISE:  reg_rdata = rise_q;
      A_FALL:  reg_rdata = fall_q;
      A_CTRL:  reg_rdata = ctrl_q;
      default: reg_rdata = '0;
    endcase
  end

  assign wen_gpio  = wen_q[NUM_GPIO-1:0];
  assign wen_rtc   = wen_q[RTC_BIT];
  assign rise_en   = rise_q[NUM_GPIO-1:0];
  assign fall_en   = fall_q[NUM_GPIO-1:0];
  assign ign_fault = ctrl_q[0];

endmodule

// File: rtl/wake_combine.sv
module wake_combine
  import wake_pkg::*;
#(
  parameter int NUM_GPIO = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GPIO-1:0] rise_evt,
  input  logic [NUM_GPIO-1:0] fall_evt,
  input  logic [NUM_GPIO-1:0] rise_en,
  input  logic [NUM_GPIO-1:0] fall_en,
  input  logic [NUM_GPIO-1:0] is_out,
  input  logic [NUM_GPIO-1:0] wen_gpio,
  input  logic                wen_rtc,
  input  logic                rtc_alarm,
  output logic [NUM_GPIO-1:0] line_evt,
  output logic                wake_req
);

  logic [REG_W-1:0] evt_w;
  logic             hit;

  assign evt_w = qual_events(REG_W'(rise_evt), REG_W'(fall_evt),
                             REG_W'(rise_en), REG_W'(fall_en), REG_W'(is_out));
  assign line_evt = evt_w[NUM_GPIO-1:0];
  assign hit = wake_hit(REG_W'(line_evt), REG_W'(wen_gpio), rtc_alarm, wen_rtc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= hit;
  end

endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_GPIO    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_GPIO-1:0] gpio_is_out,
  input  logic                rtc_alarm,
  input  logic                vdd_fault_n,
  input  logic                batt_fault_n,
  output logic                wake_req
);

  // Internal events brought out for the checker
  logic [NUM_GPIO-1:0] raw_rise, raw_fall, line_evt;
  logic [NUM_GPIO-1:0] wen_gpio, rise_en, fall_en;
  logic                wen_rtc, ign_fault, fault_force;

  wake_edge_det #(.NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (gpio_in),
    .rise_evt (raw_rise),
    .fall_evt (raw_fall)
  );

  wake_regs #(.NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .vdd_fault_n  (vdd_fault_n),
    .batt_fault_n (batt_fault_n),
    .reg_rdata    (reg_rdata),
    .wen_gpio     (wen_gpio),
    .wen_rtc      (wen_rtc),
    .rise_en      (rise_en),
    .fall_en      (fall_en),
    .ign_fault    (ign_fault),
    .fault_force  (fault_force)
  );

  wake_combine #(.NUM_GPIO(NUM_GPIO)) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_evt  (raw_rise),
    .fall_evt  (raw_fall),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .is_out    (gpio_is_out),
    .wen_gpio  (wen_gpio),
    .wen_rtc   (wen_rtc),
    .rtc_alarm (rtc_alarm),
    .line_evt  (line_evt),
    .wake_req  (wake_req)
  );

endmodule

// File: rtl/wake_src_ctrl_chk.sv
module wake_src_ctrl_chk
  import wake_pkg::*;
#(
  parameter int NUM_GPIO = 16,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [31:0]         reg_rdata,
  input logic                fault_force,
  input logic                ign_fault,
  input logic [NUM_GPIO-1:0] wen_gpio,
  input logic                wen_rtc,
  input logic [NUM_GPIO-1:0] raw_rise,
  input logic [NUM_GPIO-1:0] line_evt,
  input logic                rtc_alarm,
  input logic                wake_req
);

  localparam logic [ADDR_W-1:0] A_WEN = ADDR_W'(OFS_WEN);
  localparam logic [31:0]       M_RSV = ~wen_wmask(NUM_GPIO);

  a_r3_fault_forces_safe: assert property (@(posedge clk) disable iff (!rst_n)
    fault_force |=> (wen_gpio == NUM_GPIO'(3) && !wen_rtc));

  a_r11_fault_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_force && reg_wr && reg_addr == A_WEN) |=> (wen_gpio == NUM_GPIO'(3)));

  a_r4_ignore_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_fault && !(reg_wr && reg_addr == A_WEN)) |=> ($stable(wen_gpio) && $stable(wen_rtc)));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_WEN) |-> ((reg_rdata & M_RSV) == 32'h0));

  a_r6_edge_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw_rise) |=> ((raw_rise & $past(raw_rise)) == '0));

  a_r8_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past((|(line_evt & wen_gpio)) || (rtc_alarm && wen_rtc)));

endmodule

bind wake_src_ctrl wake_src_ctrl_chk #(.NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .fault_force (fault_force),
  .ign_fault   (ign_fault),
  .wen_gpio    (wen_gpio),
  .wen_rtc     (wen_rtc),
  .raw_rise    (raw_rise),
  .line_evt    (line_evt),
  .rtc_alarm   (rtc_alarm),
  .wake_req    (wake_req)
);

// File: tb/wake_src_ctrl_test.sv
`timescale 1ns/1ps
module wake_src_ctrl_test;

  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  gpio_in = '0;
  logic [N-1:0]  gpio_is_out = '0;
  logic          rtc_alarm = 1'b0;
  logic          vdd_fault_n = 1'b1;
  logic          batt_fault_n = 1'b1;
  logic          wake_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wake_src_ctrl #(.NUM_GPIO(N), .SYNC_STAGES(2), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
    .gpio_is_out(gpio_is_out), .rtc_alarm(rtc_alarm),
    .vdd_fault_n(vdd_fault_n), .batt_fault_n(batt_fault_n), .wake_req(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  // Change one line and check the wake pulse three edges later, then its end
  task automatic edge_try(input int line, input logic val, input logic exp, input string req);
    @(negedge clk);
    gpio_in[line] = val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, {31'h0, wake_req}, {31'h0, exp});
    @(negedge clk);
    check({req, " pulse end"}, {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_reset;
    rd_check(4'h0, 32'h0000_0003, "R2 wake-enable reset");
    rd_check(4'h4, 32'h0, "R2 rise reset");
    rd_check(4'h8, 32'h0, "R2 fall reset");
    rd_check(4'hC, 32'h0, "R2 ctrl reset");
    check("R2 wake idle", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_regmap;
    wr(4'h0, 32'hFFFF_FFFF); rd_check(4'h0, 32'h8000_FFFF, "R5 wake-enable reserved");
    wr(4'h4, 32'hFFFF_FFFF); rd_check(4'h4, 32'h0000_FFFF, "R5 rise reserved");
    wr(4'h8, 32'hA5A5_1234); rd_check(4'h8, 32'h0000_1234, "R1 fall map");
    wr(4'hC, 32'hFFFF_FFFF); rd_check(4'hC, 32'h0000_0001, "R5 ctrl reserved");
    wr(4'h2, 32'hFFFF_FFFF); rd_check(4'h2, 32'h0, "R1 unmapped offset");
    rd_check(4'h0, 32'h8000_FFFF, "R1 unmapped write harmless");
    wr(4'hC, 32'h0); wr(4'h4, 32'h0); wr(4'h8, 32'h0);
  endtask

  task automatic t_rise;
    wr(4'h0, 32'h0000_FFFF); wr(4'h4, 32'h0000_0008);
    edge_try(3, 1'b1, 1'b1, "R6 rising edge wakes");
    edge_try(3, 1'b0, 1'b0, "R7 falling ignored without fall enable");
  endtask

  task automatic t_fall;
    wr(4'h4, 32'h0); wr(4'h8, 32'h0000_0008);
    edge_try(3, 1'b1, 1'b0, "R7 rising ignored without rise enable");
    edge_try(3, 1'b0, 1'b1, "R7 falling edge wakes");
    wr(4'h8, 32'h0);
    edge_try(3, 1'b1, 1'b0, "R7 no edge enable rise");
    edge_try(3, 1'b0, 1'b0, "R7 no edge enable fall");
  endtask

  task automatic t_both;
    wr(4'h4, 32'h0000_0020); wr(4'h8, 32'h0000_0020);
    edge_try(5, 1'b1, 1'b1, "R7 both enables rise");
    edge_try(5, 1'b0, 1'b1, "R7 both enables fall");
  endtask

  task automatic t_wen_off;
    wr(4'h0, 32'h0000_FFDF);
    edge_try(5, 1'b1, 1'b0, "R8 wake enable clear rise");
    edge_try(5, 1'b0, 1'b0, "R8 wake enable clear fall");
    wr(4'h0, 32'h0000_FFFF);
  endtask

  task automatic t_output;
    gpio_is_out[5] = 1'b1;
    edge_try(5, 1'b1, 1'b0, "R9 output line rise");
    edge_try(5, 1'b0, 1'b0, "R9 output line fall");
    gpio_is_out[5] = 1'b0;
    edge_try(5, 1'b1, 1'b1, "R9 input line again wakes");
    edge_try(5, 1'b0, 1'b1, "R9 input line fall wakes");
  endtask

  task automatic t_rtc;
    wr(4'h0, 32'h8000_0000);
    @(negedge clk); rtc_alarm = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0;
    check("R10 alarm wakes", {31'h0, wake_req}, 32'h1);
    @(negedge clk); check("R10 alarm pulse end", {31'h0, wake_req}, 32'h0);
    wr(4'h0, 32'h0000_FFFF);
    @(negedge clk); rtc_alarm = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0;
    check("R10 alarm disabled", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_fault;
    wr(4'h0, 32'h8000_F0F0);
    @(negedge clk); vdd_fault_n = 1'b0;
    repeat (4) @(posedge clk);
    rd_check(4'h0, 32'h0000_0003, "R3 supply fault forces safe");
    wr(4'h0, 32'h0000_FFFF);
    rd_check(4'h0, 32'h0000_0003, "R11 fault beats write");
    @(negedge clk); vdd_fault_n = 1'b1;
    repeat (4) @(posedge clk);
    wr(4'h0, 32'h0000_1234);
    rd_check(4'h0, 32'h0000_1234, "R3 write after release");
    @(negedge clk); batt_fault_n = 1'b0;
    repeat (4) @(posedge clk);
    rd_check(4'h0, 32'h0000_0003, "R3 battery fault forces safe");
    @(negedge clk); batt_fault_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_ignore;
    wr(4'hC, 32'h1);
    wr(4'h0, 32'h8000_00F0);
    @(negedge clk); vdd_fault_n = 1'b0; batt_fault_n = 1'b0;
    repeat (5) @(posedge clk);
    rd_check(4'h0, 32'h8000_00F0, "R4 fault ignored");
    wr(4'h0, 32'h0000_0F00);
    rd_check(4'h0, 32'h0000_0F00, "R4 write works during ignored fault");
    @(negedge clk); vdd_fault_n = 1'b1; batt_fault_n = 1'b1;
    repeat (4) @(posedge clk);
    wr(4'hC, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_wen_off();
    t_output();
    t_rtc();
    t_fault();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule